// File: doc/BRIEF.md
# Endpoint DMA Burst Engine

This block is one DMA channel. It moves bytes between an endpoint FIFO and system memory over a 32-bit memory bus. Software fills in a small descriptor: a memory address, a byte count and a control word. The control word holds the direction, the packet mode, the interrupt enable, the endpoint number and the packet length. Writing the control word with its go bit set starts the channel. The engine splits the job into bus transactions and sizes each one from the bytes that are left. It uses incrementing word bursts where enough bytes remain and single word, halfword or byte accesses for the tail.

Before it asks for the bus, the engine checks that the FIFO can supply or accept the whole next transaction. On the FIFO side there are two valid/ready streams. The source stream carries bytes to be written to memory. The sink stream carries bytes read from memory and includes a byte-keep mask. Every bus transaction carries the endpoint number of the channel.

In one-packet mode the channel stops after one packet length or after the whole count, whichever is smaller. Software can then start it again to move the next packet. In multi-packet mode the channel runs until the count reaches zero.

Top module: `usb_ep_dma`

## Requirements
- R1: After reset the channel is idle. bus_req, mem_valid, src_ready, snk_valid and irq are low, and the status word reads 0.
- R2: A go request is rejected when the address register is not a multiple of 4, or when one-packet mode has a packet length of 0. In that case status bit 1 (error) is set, the channel stays idle and no bus beat is issued.
- R3: Transaction sizing uses the bytes left (L). For L >= 64 the engine issues a 16-beat word burst, for L >= 32 an 8-beat burst and for L >= 16 a 4-beat burst. Below that it issues a single word when L >= 4, a halfword when L >= 2 and a byte otherwise. mem_len is the beat count, and mem_size is 0 for a byte, 1 for a halfword and 2 for a word.
- R4: Word and burst beats have mem_addr[1:0]=0. Byte lanes are little-endian: write data sits at lane mem_addr[1:0] and up. Read data is returned on the sink stream from lane 0 upward, with snk_keep equal to 0001, 0011 or 1111.
- R5: A transaction is requested only when fifo_level is at least its byte size. fifo_level counts bytes available for a write to memory, or free bytes for a read from memory.
- R6: Each completed beat advances the address register and lowers the count register by the beat's byte size. Beats within a burst step the address by 4.
- R7: In one-packet mode the channel stops after min(count, packet length) bytes. In multi-packet mode it stops when the count reaches 0.
- R8: On completion, status bit 0 (done) is set. irq equals done AND the interrupt enable. Writing 1 to a status bit clears it, and go also clears both bits.
- R9: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_size, mem_len and mem_wdata stay unchanged.
- R10: No beat starts before bus_gnt is seen with bus_req high. mem_ep carries the programmed endpoint number and mem_write is 1 for the FIFO-to-memory direction.
- R11: While the channel is busy, writes to the control, address and count registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 address, 2 count, 3 status |
| cfg_wdata | input | 32 | Write data. Control bits: 0 go, 1 dir (1 = memory to FIFO), 2 multi, 3 irq enable, 7:4 endpoint, 18:8 packet length |
| cfg_rdata | output | 32 | Read data of the selected register. Status bits: 0 done, 1 error, 2 busy |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Beat valid |
| mem_ready | input | 1 | Beat accepted |
| mem_write | output | 1 | 1 = write to memory |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_len | output | 5 | Beats in the current transaction (1, 4, 8, 16) |
| mem_ep | output | 4 | Endpoint tag |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| fifo_level | input | 12 | FIFO bytes available (write) or free (read) |
| src_valid | input | 1 | Source stream valid |
| src_ready | output | 1 | Source stream ready |
| src_data | input | 32 | Source bytes, lowest lane first |
| snk_valid | output | 1 | Sink stream valid |
| snk_ready | input | 1 | Sink stream ready |
| snk_data | output | 32 | Sink bytes from lane 0 |
| snk_keep | output | 4 | Sink byte-keep mask |

## Verification
Some rules are checked by the assertions on every cycle. These are: word alignment of word beats, word size for every burst, stable outputs while a beat stalls, no beat without a pending request, no underflow of the count, and an idle channel while error or done is set. Other behaviour can only be shown by the bench scenarios. These are the exact sequence of burst and single sizes for a given count, the lane placement of tail bytes, the packet boundary in one-packet mode, gating on the FIFO level, and registers that refuse writes while busy.

// File: rtl/usb_ep_dma.sv
module usb_ep_dma #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int LW  = 12,
  parameter int EPW = 4,
  parameter int PW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [4:0]    mem_len,
  output logic [EPW-1:0] mem_ep,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic [LW-1:0] fifo_level,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [31:0]   src_data,
  output logic          snk_valid,
  input  logic          snk_ready,
  output logic [31:0]   snk_data,
  output logic [3:0]    snk_keep
);

  localparam int BIT_GO  = 0;
  localparam int BIT_DIR = 1;
  localparam int BIT_MUL = 2;
  localparam int BIT_IEN = 3;
  localparam int EP_LSB  = 4;
  localparam int PK_LSB  = 8;

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_FETCH, S_BUS, S_PUSH} st_t;

  st_t           st;
  logic          dir_q, multi_q, ien_q;
  logic [EPW-1:0] ep_q;
  logic [PW-1:0] pkt_cfg_q;
  logic [CW-1:0] pkt_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          done_q, err_q;
  logic [1:0]    size_q;
  logic [4:0]    len_q, beats_q;
  logic [31:0]   hold_q, rhold_q;

  logic [CW-1:0] xfer_left;
  logic [4:0]    pick_len;
  logic [1:0]    pick_size;
  logic [6:0]    pick_bytes;
  logic [2:0]    nb;
  logic          lvl_ok, busy, beat_done, last_beat, xfer_end;
  logic          go_req, bad_start;

  assign busy      = (st != S_IDLE);
  assign xfer_left = multi_q ? cnt_q : ((cnt_q < pkt_q) ? cnt_q : pkt_q);

  always_comb begin
    pick_len  = 5'd1;
    pick_size = 2'd2;
    if (xfer_left >= CW'(64))      pick_len = 5'd16;
    else if (xfer_left >= CW'(32)) pick_len = 5'd8;
    else if (xfer_left >= CW'(16)) pick_len = 5'd4;
    else if (xfer_left >= CW'(4))  pick_len = 5'd1;
    else if (xfer_left >= CW'(2))  pick_size = 2'd1;
    else                           pick_size = 2'd0;
  end

  assign pick_bytes = (pick_size == 2'd2) ? {pick_len, 2'b00} :
                      (pick_size == 2'd1) ? 7'd2 : 7'd1;
  assign lvl_ok     = fifo_level >= LW'(pick_bytes);
  assign nb         = (size_q == 2'd2) ? 3'd4 : (size_q == 2'd1) ? 3'd2 : 3'd1;
  assign last_beat  = (beats_q == 5'd1);
  assign xfer_end   = last_beat && (xfer_left == CW'(nb));
  assign beat_done  = (st == S_BUS && mem_ready && !dir_q) ||
                      (st == S_PUSH && snk_ready);

  assign go_req    = cfg_we && (cfg_sel == 2'd0) && cfg_wdata[BIT_GO] && !busy;
  assign bad_start = (addr_q[1:0] != 2'b00) ||
                     (!cfg_wdata[BIT_MUL] && (cfg_wdata[PK_LSB +: PW] == '0));

  assign bus_req   = (st == S_ARB && lvl_ok) || st == S_FETCH || st == S_BUS || st == S_PUSH;
  assign mem_valid = (st == S_BUS);
  assign mem_write = !dir_q;
  assign mem_addr  = addr_q;
  assign mem_size  = size_q;
  assign mem_len   = len_q;
  assign mem_ep    = ep_q;
  assign mem_wdata = hold_q << {addr_q[1:0], 3'b000};
  assign src_ready = (st == S_FETCH);
  assign snk_valid = (st == S_PUSH);
  assign snk_data  = rhold_q;
  assign snk_keep  = (size_q == 2'd2) ? 4'b1111 : (size_q == 2'd1) ? 4'b0011 : 4'b0001;
  assign irq       = done_q && ien_q;

  always_comb begin
    case (cfg_sel)
      2'd0:    cfg_rdata = 32'({pkt_cfg_q, ep_q, ien_q, multi_q, dir_q, 1'b0});
      2'd1:    cfg_rdata = 32'(addr_q);
      2'd2:    cfg_rdata = 32'(cnt_q);
      default: cfg_rdata = {29'd0, busy, err_q, done_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dir_q     <= 1'b0;
      multi_q   <= 1'b0;
      ien_q     <= 1'b0;
      ep_q      <= '0;
      pkt_cfg_q <= '0;
      pkt_q     <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      size_q    <= 2'd0;
      len_q     <= 5'd1;
      beats_q   <= 5'd0;
      hold_q    <= '0;
      rhold_q   <= '0;
    end else begin
      if (cfg_we && cfg_sel == 2'd3) begin
        if (cfg_wdata[0]) done_q <= 1'b0;
        if (cfg_wdata[1]) err_q  <= 1'b0;
      end
      if (cfg_we && !busy && cfg_sel == 2'd1) addr_q <= cfg_wdata[AW-1:0];
      if (cfg_we && !busy && cfg_sel == 2'd2) cnt_q  <= cfg_wdata[CW-1:0];
      if (cfg_we && !busy && cfg_sel == 2'd0) begin
        dir_q     <= cfg_wdata[BIT_DIR];
        multi_q   <= cfg_wdata[BIT_MUL];
        ien_q     <= cfg_wdata[BIT_IEN];
        ep_q      <= cfg_wdata[EP_LSB +: EPW];
        pkt_cfg_q <= cfg_wdata[PK_LSB +: PW];
        pkt_q     <= CW'(cfg_wdata[PK_LSB +: PW]);
      end
      if (go_req) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
        if (bad_start)          err_q  <= 1'b1;
        else if (cnt_q == '0)   done_q <= 1'b1;
        else                    st     <= S_ARB;
      end

      case (st)
        S_ARB: if (lvl_ok && bus_gnt) begin
          size_q  <= pick_size;
          len_q   <= pick_len;
          beats_q <= pick_len;
          st      <= dir_q ? S_BUS : S_FETCH;
        end
        S_FETCH: if (src_valid) begin
          hold_q <= src_data;
          st     <= S_BUS;
        end
        S_BUS: if (mem_ready && dir_q) begin
          rhold_q <= mem_rdata >> {addr_q[1:0], 3'b000};
          st      <= S_PUSH;
        end
        default: ;
      endcase

      if (beat_done) begin
        addr_q  <= addr_q + AW'(nb);
        cnt_q   <= cnt_q - CW'(nb);
        if (!multi_q) pkt_q <= pkt_q - CW'(nb);
        beats_q <= beats_q - 5'd1;
        if (xfer_end) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else if (last_beat) st <= S_ARB;
        else                    st <= dir_q ? S_BUS : S_FETCH;
      end
    end
  end

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_size == 2'd2 |-> mem_addr[1:0] == 2'b00); // R4
  AST_BURST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_len != 5'd1 |-> mem_size == 2'd2); // R3
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_size) && $stable(mem_len) && $stable(mem_wdata)); // R9
  AST_REQ_COVERS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_req); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |-> cnt_q >= CW'(nb)); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !mem_valid && !snk_valid && !src_ready); // R8
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !bus_req && !mem_valid); // R2

endmodule

// File: tb/usb_ep_dma_bench.sv
module usb_ep_dma_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq, bus_req, mem_valid, mem_write, src_ready, snk_valid;
  logic        bus_gnt = 1'b0, mem_ready = 1'b0, src_valid = 1'b1, snk_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, snk_data;
  logic [31:0] mem_rdata = '0, src_data = '0;
  logic [1:0]  mem_size;
  logic [4:0]  mem_len;
  logic [3:0]  mem_ep, snk_keep;
  logic [11:0] fifo_level = 12'hFFF;

  usb_ep_dma u_usb_ep_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_len(mem_len), .mem_ep(mem_ep), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .fifo_level(fifo_level), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data),
    .snk_keep(snk_keep)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [4:0]  len;
    logic [3:0]  ep;
    logic        wr;
    logic [31:0] data;
    logic [31:0] mask;
  } beat_t;

  beat_t      exp_q[$];
  logic [7:0] byte_q[$];
  int tests = 0, fails = 0, cycles = 0;
  int src_idx = 0, exp_sw = 0;
  logic src_take = 1'b0, gnt_en = 1'b1, stall_en = 1'b1;
  logic [7:0] lfsr = 8'h5B;

  function automatic logic [31:0] src_word(int idx);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'((idx * 4 + i)) ^ 8'h3C;
    return w;
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] w;
    logic [31:0] base;
    base = {a[31:2], 2'b00};
    for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'(base + 32'(i)) ^ 8'hA5;
    return w;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // driver: expected beats from the sizing rule of R3 and lane rule of R4
  task automatic plan(input logic rd, input logic [31:0] a0, input int n, input logic [3:0] ep);
    logic [31:0] a;
    int left, len, sz, nbytes;
    beat_t e;
    a = a0;
    left = n;
    while (left > 0) begin
      sz = 2; len = 1;
      if (left >= 64) len = 16;
      else if (left >= 32) len = 8;
      else if (left >= 16) len = 4;
      else if (left >= 4) len = 1;
      else if (left >= 2) sz = 1;
      else sz = 0;
      nbytes = (sz == 2) ? 4 : (sz == 1) ? 2 : 1;
      for (int b = 0; b < len; b++) begin
        logic [31:0] lm;
        lm = (nbytes == 4) ? 32'hFFFF_FFFF : (nbytes == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
        e.addr = a; e.size = 2'(sz); e.len = 5'(len); e.ep = ep; e.wr = !rd;
        e.mask = lm << {a[1:0], 3'b000};
        e.data = rd ? 32'd0 : ((src_word(exp_sw) & lm) << {a[1:0], 3'b000});
        if (!rd) exp_sw++;
        else for (int j = 0; j < nbytes; j++) byte_q.push_back(8'(a + 32'(j)) ^ 8'hA5);
        exp_q.push_back(e);
        a = a + 32'(nbytes);
        left = left - nbytes;
      end
    end
  endtask

  // slave, source, sink and monitor, all at the falling edge
  always @(negedge clk) begin
    beat_t e;
    cycles++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_gnt = gnt_en && bus_req;
    mem_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
    mem_rdata = mem_word(mem_addr);
    snk_ready = stall_en ? (lfsr[1] | lfsr[4]) : 1'b1;
    if (src_take) src_idx++;
    src_data = src_word(src_idx);
    src_take = src_valid && src_ready;
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R2/R10 unexpected beat", mem_addr, 32'd0);
      else begin
        e = exp_q.pop_front();
        chk(mem_addr == e.addr, "R6 beat address", mem_addr, e.addr);
        chk(mem_size == e.size && mem_len == e.len, "R3 beat size/len",
            {mem_size, mem_len}, {e.size, e.len});
        chk(mem_ep == e.ep && mem_write == e.wr, "R10 endpoint tag/dir",
            {mem_write, mem_ep}, {e.wr, e.ep});
        if (e.wr) chk((mem_wdata & e.mask) == e.data, "R4 write lanes", mem_wdata & e.mask, e.data);
      end
    end
    if (rst_n && snk_valid && snk_ready) begin
      for (int j = 0; j < 4; j++) if (snk_keep[j]) begin
        logic [7:0] eb;
        eb = (byte_q.size() != 0) ? byte_q.pop_front() : 8'hXX;
        chk(snk_data[8*j +: 8] === eb, "R4 read lanes", 32'(snk_data[8*j +: 8]), 32'(eb));
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk); cfg_sel = sel; #1; v = cfg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd3, v);
      if (v[2] == 1'b0) break;
    end
  endtask

  function automatic logic [31:0] mk_ctl(logic rdir, logic mul, logic ien, logic [3:0] ep, int pkt);
    return {13'd0, 11'(pkt), ep, ien, mul, rdir, 1'b1};
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk(cfg_rdata == 32'd0, "R1 status after reset", cfg_rdata, 32'd0);
    chk(!bus_req && !mem_valid && !src_ready && !snk_valid && !irq, "R1 idle outputs",
        {bus_req, mem_valid, src_ready, snk_valid, irq}, 0);
    rst_n = 1'b1;

    // R2 misaligned address
    wr(2'd1, 32'h0000_0102); wr(2'd2, 32'd16);
    wr(2'd0, mk_ctl(1'b0, 1'b1, 1'b1, 4'd2, 0));
    repeat (10) @(negedge clk);
    rd(2'd3, v);
    chk(v == 32'h2, "R2 misaligned -> error, idle", v, 32'h2);
    chk(!irq, "R8 no irq on error", irq, 0);
    wr(2'd3, 32'h2);
    rd(2'd3, v);
    chk(v == 32'h0, "R8 W1C error", v, 32'h0);
    // R2 one-packet mode with zero packet length
    wr(2'd1, 32'h0000_0100);
    wr(2'd0, mk_ctl(1'b0, 1'b0, 1'b0, 4'd2, 0));
    repeat (5) @(negedge clk);
    rd(2'd3, v);
    chk(v == 32'h2, "R2 zero packet length -> error", v, 32'h2);
    wr(2'd3, 32'h2);

    // R3 R4 R6 R7 multi write, 119 bytes
    wr(2'd1, 32'h0000_1000); wr(2'd2, 32'd119);
    plan(1'b0, 32'h1000, 119, 4'd5);
    wr(2'd0, mk_ctl(1'b0, 1'b1, 1'b1, 4'd5, 0));
    wait_done();
    rd(2'd1, v); chk(v == 32'h1077, "R6 final address", v, 32'h1077);
    rd(2'd2, v); chk(v == 32'd0, "R7 multi count to zero", v, 0);
    rd(2'd3, v); chk(v == 32'h1, "R8 done set", v, 32'h1);
    chk(irq == 1'b1, "R8 irq with enable", irq, 1);
    wr(2'd3, 32'h1);
    #1; chk(irq == 1'b0, "R8 irq cleared by W1C", irq, 0);

    // R3 R4 multi read, 43 bytes
    wr(2'd1, 32'h0000_2000); wr(2'd2, 32'd43);
    plan(1'b1, 32'h2000, 43, 4'd9);
    wr(2'd0, mk_ctl(1'b1, 1'b1, 1'b0, 4'd9, 0));
    wait_done();
    rd(2'd1, v); chk(v == 32'h202B, "R6 read final address", v, 32'h202B);
    chk(byte_q.size() == 0, "R4 all read bytes delivered", byte_q.size(), 0);

    // R7 one-packet mode, pkt 20, count 50
    wr(2'd1, 32'h0000_3000); wr(2'd2, 32'd50);
    plan(1'b0, 32'h3000, 20, 4'd3);
    wr(2'd0, mk_ctl(1'b0, 1'b0, 1'b0, 4'd3, 20));
    wait_done();
    rd(2'd2, v); chk(v == 32'd30, "R7 stop after one packet", v, 32'd30);
    rd(2'd1, v); chk(v == 32'h3014, "R7 packet end address", v, 32'h3014);
    rd(2'd3, v); chk(v == 32'h1, "R8 done in one-packet mode", v, 32'h1);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    plan(1'b0, 32'h3014, 20, 4'd3);
    wr(2'd0, mk_ctl(1'b0, 1'b0, 1'b0, 4'd3, 20));
    wait_done();
    plan(1'b0, 32'h3028, 10, 4'd3);
    wr(2'd0, mk_ctl(1'b0, 1'b0, 1'b0, 4'd3, 20));
    wait_done();
    rd(2'd2, v); chk(v == 32'd0, "R7 short last packet", v, 0);
    rd(2'd1, v); chk(v == 32'h3032, "R7 final address", v, 32'h3032);

    // R5 level gating
    fifo_level = 12'd15;
    wr(2'd1, 32'h0000_4000); wr(2'd2, 32'd16);
    plan(1'b0, 32'h4000, 16, 4'd1);
    wr(2'd0, mk_ctl(1'b0, 1'b1, 1'b0, 4'd1, 0));
    repeat (20) @(negedge clk);
    #1;
    chk(!bus_req && !mem_valid, "R5 no request below level", {bus_req, mem_valid}, 0);
    chk(exp_q.size() == 4, "R5 no beats below level", exp_q.size(), 4);
    fifo_level = 12'd16;
    wait_done();
    chk(exp_q.size() == 0, "R5 runs at exact level", exp_q.size(), 0);
    fifo_level = 12'hFFF;

    // R10 grant gating, R11 busy writes ignored
    gnt_en = 1'b0;
    wr(2'd1, 32'h0000_5000); wr(2'd2, 32'd8);
    plan(1'b0, 32'h5000, 8, 4'd7);
    wr(2'd0, mk_ctl(1'b0, 1'b1, 1'b0, 4'd7, 0));
    repeat (10) @(negedge clk);
    #1;
    chk(bus_req == 1'b1 && exp_q.size() == 2, "R10 wait for grant", {bus_req, 8'(exp_q.size())}, {1'b1, 8'd2});
    wr(2'd1, 32'h000D_EAD0);
    wr(2'd2, 32'd99);
    wr(2'd0, mk_ctl(1'b1, 1'b0, 1'b1, 4'd2, 4));
    rd(2'd0, v);
    chk(v[7:1] == 7'b0111_010, "R11 control unchanged while busy", 32'(v[7:1]), 32'h3A);
    gnt_en = 1'b1;
    wait_done();
    rd(2'd1, v); chk(v == 32'h5008, "R11 address write ignored", v, 32'h5008);
    rd(2'd2, v); chk(v == 32'd0, "R11 count write ignored", v, 0);

    chk(exp_q.size() == 0, "R3 all planned beats seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule